// File: doc/BRIEF.md
# Serial Operand Framer for a Multiplier

The block joins a multiplier to one full-duplex asynchronous serial link. Two bytes that arrive one after the other on the receive line become a single multiply request. The first byte is the first operand and the second byte is the second operand. The block raises a one-cycle start strobe and holds both operands steady. When the multiplier reports that it is finished, the block captures the double-width product and returns it on the transmit line as two bytes.

Both directions share one free-running tick generator. The tick runs at sixteen times the bit rate. The receiver uses these ticks to find the middle of each bit. The transmitter uses them to hold every bit for exactly one bit period. Frames use one start bit, eight data bits sent least-significant first, no parity and one stop bit. While the block is busy with a request, new input is not accepted until the low result byte has completely left the transmit line.

Top module: `uart_mul_framer`

## Requirements
- R1: After reset, txSerial is at logic 1 and mulStart is 0. txSerial stays at 1 whenever no frame is being sent.
- R2: A receive frame is a 0 start bit, then DATA_W data bits least-significant bit first, then a 1 stop bit. Each bit lasts OVERSAMPLE*TICK_DIV clocks, which is 64 clocks with the default parameters. The first accepted byte appears on mulOpA and the second on mulOpB. After the second byte, mulStart pulses high for exactly one clock.
- R3: mulOpA and mulOpB keep their values from the mulStart pulse until mulDone is seen.
- R4: After mulDone, the 2*DATA_W-bit mulProduct is sent as two frames in the same format as R2. The upper half goes out first and the lower half second, each least-significant bit first.
- R5: The start bit of the low result byte begins no earlier than ten full bit periods after the start bit of the high byte. This means the low byte starts only once the high byte's stop bit has ended.
- R6: A low pulse on rxSerial that is back at 1 by the middle of the start bit is discarded. It produces no byte.
- R7: A frame whose stop bit is sampled as 0 is discarded. The receiver then waits for the line to return to 1 before it looks for a new start bit.
- R8: Bytes that complete while a request is in progress are ignored. This lasts from the second operand until the low result byte has been fully sent. The next two bytes after that form the next operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxSerial | input | 1 | Serial receive line, idle high |
| txSerial | output | 1 | Serial transmit line, idle high |
| mulStart | output | 1 | One-cycle request to the multiplier |
| mulOpA | output | DATA_W (8) | First received operand |
| mulOpB | output | DATA_W (8) | Second received operand |
| mulDone | input | 1 | Multiplier finished; mulProduct is valid in this cycle |
| mulProduct | input | 2*DATA_W (16) | Product from the multiplier |

## Verification
Directed operand pairs cover several sign cases:
- two negatives (0xF0 by 0xF1);
- two positives (17 by 57);
- the most negative value squared;
- mixed extremes;
- a zero factor.

These pairs separate a swapped byte order, a wrong bit order or a wrong operand slot, because each of those produces a different returned byte pair. A seeded random series then covers arbitrary bit patterns, with a varying multiplier latency that tests operand holding.

Three line patterns target the receiver and the sequencing:
- a short low glitch;
- a frame with a low stop bit;
- an extra byte sent while the result is going out.

In each case, a following clean pair must reach the multiplier unchanged, so any wrongly accepted byte shows up as a wrong operand.

// File: rtl/uart_mul_framer_pkg.sv
package uart_mul_framer_pkg;

  // Strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic loadA;   // capture received byte as first operand
    logic loadB;   // capture received byte as second operand
    logic capRes;  // capture multiplier product
    logic loadTx;  // start a transmit frame
    logic selHi;   // pick upper product half for loadTx
  } frmStrb_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rxSt_t;

  typedef enum logic [2:0] {
    C_OPA,
    C_OPB,
    C_START,
    C_WAIT,
    C_HI,
    C_HIDRAIN,
    C_LO,
    C_LODRAIN
  } ctlSt_t;

endpackage

// File: rtl/uart_mul_framer_dp.sv
module uart_mul_framer_dp
  import uart_mul_framer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxSerial,
  input  frmStrb_t            strb,
  input  logic [2*DATA_W-1:0] mulProduct,
  output logic                txSerial,
  output logic                rxValid,
  output logic                txBusy,
  output logic [DATA_W-1:0]   mulOpA,
  output logic [DATA_W-1:0]   mulOpB
);

  localparam int RES_W   = 2 * DATA_W;
  localparam int FRAME_W = DATA_W + 2;
  localparam int DIV_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int OS_W    = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int CNT_W   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int FBIT_W  = $clog2(FRAME_W);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(OVERSAMPLE - 1);
  localparam logic [OS_W-1:0] OS_MID  = OS_W'(OVERSAMPLE / 2 - 1);

  // ---------------- tick generator (shared) ----------------
  logic [DIV_W-1:0] divCnt;
  logic             tick;

  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // ---------------- receiver ----------------
  logic [1:0]        rxSync;
  logic              rxBit;
  rxSt_t             rxState;
  logic [OS_W-1:0]   rxOs;
  logic [CNT_W-1:0]  rxCnt;
  logic [DATA_W-1:0] rxShift;

  assign rxBit = rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxSerial};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxOs    <= '0;
      rxCnt   <= '0;
      rxShift <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      unique case (rxState)
        RX_IDLE: begin
          if (tick && !rxBit) begin
            rxState <= RX_START;
            rxOs    <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rxOs == OS_MID) begin
              rxOs  <= '0;
              rxCnt <= '0;
              // still low at mid start bit: real frame; otherwise a glitch
              rxState <= rxBit ? RX_IDLE : RX_DATA;
            end else begin
              rxOs <= rxOs + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (rxOs == OS_LAST) begin
              rxOs    <= '0;
              rxShift <= {rxBit, rxShift[DATA_W-1:1]};
              if (rxCnt == CNT_W'(DATA_W - 1)) rxState <= RX_STOP;
              else                             rxCnt   <= rxCnt + 1'b1;
            end else begin
              rxOs <= rxOs + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (rxOs == OS_LAST) begin
              rxOs <= '0;
              if (rxBit) begin
                rxValid <= 1'b1;
                rxState <= RX_IDLE;
              end else begin
                rxState <= RX_BREAK;
              end
            end else begin
              rxOs <= rxOs + 1'b1;
            end
          end
        end
        RX_BREAK: begin
          if (rxBit) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  // ---------------- operand and result registers ----------------
  logic [RES_W-1:0] resReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mulOpA <= '0;
      mulOpB <= '0;
      resReg <= '0;
    end else begin
      if (strb.loadA)  mulOpA <= rxShift;
      if (strb.loadB)  mulOpB <= rxShift;
      if (strb.capRes) resReg <= mulProduct;
    end
  end

  // ---------------- transmitter ----------------
  logic [FRAME_W-1:0] txShift;
  logic               txPending;
  logic               txActive;
  logic [OS_W-1:0]    txOs;
  logic [FBIT_W-1:0]  txBitCnt;
  logic [DATA_W-1:0]  txByte;

  assign txByte   = strb.selHi ? resReg[RES_W-1:DATA_W] : resReg[DATA_W-1:0];
  assign txBusy   = txPending | txActive;
  assign txSerial = txActive ? txShift[0] : 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift   <= '1;
      txPending <= 1'b0;
      txActive  <= 1'b0;
      txOs      <= '0;
      txBitCnt  <= '0;
    end else if (strb.loadTx) begin
      txShift   <= {1'b1, txByte, 1'b0};
      txPending <= 1'b1;
    end else if (txPending && tick) begin
      // align the start bit to a tick so every bit spans a full period
      txPending <= 1'b0;
      txActive  <= 1'b1;
      txOs      <= '0;
      txBitCnt  <= '0;
    end else if (txActive && tick) begin
      if (txOs == OS_LAST) begin
        txOs    <= '0;
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
        if (txBitCnt == FBIT_W'(FRAME_W - 1)) txActive <= 1'b0;
        else                                  txBitCnt <= txBitCnt + 1'b1;
      end else begin
        txOs <= txOs + 1'b1;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_tx_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txSerial);

  assert_tx_load_when_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTx |-> !txBusy);

  assert_rx_byte_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  assert_ops_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadA |=> $stable(mulOpA));

endmodule

// File: rtl/uart_mul_framer_ctrl.sv
module uart_mul_framer_ctrl
  import uart_mul_framer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxValid,
  input  logic     txBusy,
  input  logic     mulDone,
  output frmStrb_t strb,
  output logic     mulStart
);

  ctlSt_t state, nextState;

  always_comb begin
    strb        = '0;
    strb.loadA  = (state == C_OPA) && rxValid;
    strb.loadB  = (state == C_OPB) && rxValid;
    strb.capRes = (state == C_WAIT) && mulDone;
    strb.loadTx = ((state == C_HI) || (state == C_LO)) && !txBusy;
    strb.selHi  = (state == C_HI);
  end

  assign mulStart = (state == C_START);

  always_comb begin
    nextState = state;
    unique case (state)
      C_OPA:     if (rxValid) nextState = C_OPB;
      C_OPB:     if (rxValid) nextState = C_START;
      C_START:   nextState = C_WAIT;
      C_WAIT:    if (mulDone) nextState = C_HI;
      C_HI:      if (!txBusy) nextState = C_HIDRAIN;
      C_HIDRAIN: if (!txBusy) nextState = C_LO;
      C_LO:      if (!txBusy) nextState = C_LODRAIN;
      C_LODRAIN: if (!txBusy) nextState = C_OPA;
      default:   nextState = C_OPA;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= C_OPA;
    else       state <= nextState;
  end

  // ---------------- assertions ----------------
  assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    mulStart |=> !mulStart);

  assert_no_load_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state inside {C_START, C_WAIT, C_HI, C_HIDRAIN, C_LO, C_LODRAIN})
      |-> !(strb.loadA || strb.loadB));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.loadA, strb.loadB, strb.capRes, strb.loadTx}));

  assert_hi_before_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadTx && !strb.selHi) |-> (state == C_LO));

endmodule

// File: rtl/uart_mul_framer.sv
module uart_mul_framer
  import uart_mul_framer_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  parameter int TICK_DIV   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxSerial,
  output logic                txSerial,
  output logic                mulStart,
  output logic [DATA_W-1:0]   mulOpA,
  output logic [DATA_W-1:0]   mulOpB,
  input  logic                mulDone,
  input  logic [2*DATA_W-1:0] mulProduct
);

  frmStrb_t strb;
  logic     rxValid;
  logic     txBusy;

  uart_mul_framer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxValid  (rxValid),
    .txBusy   (txBusy),
    .mulDone  (mulDone),
    .strb     (strb),
    .mulStart (mulStart)
  );

  uart_mul_framer_dp #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE),
    .TICK_DIV   (TICK_DIV)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxSerial   (rxSerial),
    .strb       (strb),
    .mulProduct (mulProduct),
    .txSerial   (txSerial),
    .rxValid    (rxValid),
    .txBusy     (txBusy),
    .mulOpA     (mulOpA),
    .mulOpB     (mulOpB)
  );

endmodule

// File: tb/tb_uart_mul_framer.sv
module tb_uart_mul_framer;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OVERSAMPLE = 16;
  localparam int BIT        = TICK_DIV * OVERSAMPLE;
  localparam int HALF       = BIT / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxSerial = 1'b1;
  logic        txSerial;
  logic        mulStart;
  logic [7:0]  mulOpA, mulOpB;
  logic        mulDone = 1'b0;
  logic [15:0] mulProduct = '0;

  uart_mul_framer #(.DATA_W(8), .OVERSAMPLE(OVERSAMPLE), .TICK_DIV(TICK_DIV)) dut (
    .clk(clk), .rstN(rstN), .rxSerial(rxSerial), .txSerial(txSerial),
    .mulStart(mulStart), .mulOpA(mulOpA), .mulOpB(mulOpB),
    .mulDone(mulDone), .mulProduct(mulProduct)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expProd(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] p;
    p = $signed(a) * $signed(b);
    return p;
  endfunction

  // ---------------- multiplier model ----------------
  logic [7:0] expA, expB;
  string      pairTag = "R2";
  int         startCount = 0;
  logic [7:0] lastA;

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && mulStart) begin
        logic [7:0] capA, capB;
        bit stableOk;
        int lat;
        capA = mulOpA;
        capB = mulOpB;
        lastA = capA;
        startCount++;
        check(capA == expA, {pairTag, " first operand"}, capA, expA);
        check(capB == expB, {pairTag, " second operand"}, capB, expB);
        @(negedge clk);
        check(!mulStart, "R2 start is one cycle", mulStart, 0);
        lat = $urandom_range(1, 30);
        stableOk = 1'b1;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (mulOpA != capA || mulOpB != capB) stableOk = 1'b0;
        end
        check(stableOk, "R3 operands held until done", {mulOpA, mulOpB}, {capA, capB});
        mulProduct = expProd(capA, capB);
        mulDone = 1'b1;
        @(negedge clk);
        mulDone = 1'b0;
        mulProduct = '0;
      end
    end
  end

  // ---------------- serial monitor on txSerial ----------------
  logic [7:0] rxBuf [0:127];
  int         rxTime [0:127];
  int         rxCount = 0;

  initial begin
    @(posedge rstN);
    forever begin
      int t0;
      logic [7:0] d;
      @(negedge txSerial);
      t0 = cyc;
      repeat (HALF) @(negedge clk);
      check(txSerial == 1'b0, "R4 start bit low", txSerial, 0);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        d[i] = txSerial;
      end
      repeat (BIT) @(negedge clk);
      check(txSerial == 1'b1, "R4 stop bit high", txSerial, 1);
      rxBuf[rxCount % 128]  = d;
      rxTime[rxCount % 128] = t0;
      rxCount++;
    end
  end

  // ---------------- line drivers ----------------
  task automatic sendByte(input logic [7:0] d, input bit goodStop);
    @(negedge clk);
    rxSerial = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxSerial = d[i];
      repeat (BIT) @(negedge clk);
    end
    rxSerial = goodStop;
    repeat (BIT) @(negedge clk);
    rxSerial = 1'b1;
  endtask

  task automatic runPair(input logic [7:0] a, input logic [7:0] b,
                         input bit withExtra, input logic [7:0] extra);
    int base, st0;
    logic [15:0] e;
    expA = a;
    expB = b;
    base = rxCount;
    st0  = startCount;
    sendByte(a, 1'b1);
    sendByte(b, 1'b1);
    if (withExtra) sendByte(extra, 1'b1);
    for (int k = 0; k < 40 * BIT && rxCount < base + 2; k++) @(negedge clk);
    e = expProd(a, b);
    check(rxCount >= base + 2, "R4 two result bytes", rxCount - base, 2);
    check(rxBuf[base % 128] == e[15:8], "R4 high byte first", rxBuf[base % 128], e[15:8]);
    check(rxBuf[(base + 1) % 128] == e[7:0], "R4 low byte second",
          rxBuf[(base + 1) % 128], e[7:0]);
    check(rxTime[(base + 1) % 128] - rxTime[base % 128] >= 10 * BIT,
          "R5 low byte after high stop",
          rxTime[(base + 1) % 128] - rxTime[base % 128], 10 * BIT);
    check(startCount == st0 + 1, {pairTag, " one request per pair"}, startCount - st0, 1);
    repeat (BIT) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 190000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int st0;
    void'($urandom(32'h5eed));
    repeat (5) @(negedge clk);
    check(txSerial == 1'b1, "R1 tx idle in reset", txSerial, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txSerial == 1'b1, "R1 tx idle after reset", txSerial, 1);
    check(mulStart == 1'b0, "R1 no start after reset", mulStart, 0);

    // directed sign cases (R2, R4)
    runPair(8'hF0, 8'hF1, 1'b0, 8'h00);
    runPair(8'd17, 8'd57, 1'b0, 8'h00);
    runPair(8'h80, 8'h80, 1'b0, 8'h00);
    runPair(8'h7F, 8'h81, 1'b0, 8'h00);
    runPair(8'h00, 8'hFF, 1'b0, 8'h00);

    // seeded random pairs
    for (int n = 0; n < 12; n++)
      runPair(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), 1'b0, 8'h00);

    // R6: short low glitch must not become a byte
    pairTag = "R6";
    st0 = startCount;
    @(negedge clk);
    rxSerial = 1'b0;
    repeat (3 * TICK_DIV) @(negedge clk);
    rxSerial = 1'b1;
    repeat (3 * BIT) @(negedge clk);
    runPair(8'h3C, 8'hA5, 1'b0, 8'h00);
    check(startCount == st0 + 1, "R6 glitch produced no request", startCount - st0, 1);

    // R7: bad stop bit discards the frame
    pairTag = "R7";
    sendByte(8'h5A, 1'b0);
    repeat (2 * BIT) @(negedge clk);
    runPair(8'h12, 8'hE7, 1'b0, 8'h00);

    // R8: byte arriving while the result is being sent is ignored
    pairTag = "R8";
    st0 = startCount;
    runPair(8'h09, 8'hF7, 1'b1, 8'hC3);
    runPair(8'h66, 8'h02, 1'b0, 8'h00);
    check(startCount == st0 + 2, "R8 extra byte ignored", startCount - st0, 2);
    check(lastA == 8'h66, "R8 next pair starts clean", lastA, 8'h66);

    repeat (2 * BIT) @(negedge clk);
    check(txSerial == 1'b1, "R1 tx idle at end", txSerial, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule